// File: doc/BRIEF.md
# Fractional-Trim One-Second Prescaler

This block turns a free-running timebase tick into one pulse per second. The divide ratio has two parts. The first is a 17-bit integer tick count. The second is a 2-bit fraction that stretches some seconds by one extra tick. Over a four-second rotation the average period can therefore be trimmed in quarter-tick steps. At the default scale of 65,536 ticks per nominal second, this gives a range of about ±988 ppm with a resolution of about 3.8 ppm.

Software supplies a new integer/fraction pair with a load strobe. The pair waits in a pending slot and becomes active only when the current second ends. A second that is already running keeps the length it started with. Beside the second pulse, the block gives a 7-bit sub-second position with 1/128-second resolution and a pulse each time that position advances.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: Reset is synchronous and active-low. After reset the sub-second position is 0, no pulse is high, the active integer is the nominal count (parameter, default 0x10000) and the active fraction is 0.
- R2: With fraction 0, the second pulse is high for one cycle after every P ticks, where P is the active integer.
- R3: A free-running second index k steps 0,1,2,3,0 at each second pulse. Second k lasts P+1 ticks when k is below the active fraction Q, and P ticks otherwise.
- R4: A loaded pair takes effect at the next second pulse. The second in progress keeps its old length, and the active pair changes only in a cycle that shows the second pulse.
- R5: A loaded integer below the lower limit (default 0x0FFBF) is replaced by that limit. One above the upper limit (default 0x10040) is replaced by the upper limit.
- R6: The sub-second position equals min(e >> (L-7), 127). Here e is the tick count since the last second pulse and 2^L is the nominal count (default L=16). The position is 0 in the cycle of the second pulse and never decreases within a second.
- R7: The sub-second pulse is high for one cycle when e reaches a nonzero multiple of 2^(L-7) whose position is at most 127. It is never high together with the second pulse.
- R8: A cycle without a tick changes nothing: the position holds and neither pulse is raised.
- R9: A load in the same cycle as the last tick of a second does not affect the next second. It takes effect at the pulse after that, and the pair that was already pending is applied at this boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick enable |
| load_i | input | 1 | Load strobe for a new integer/fraction pair |
| p_i | input | 17 | Integer divide count to load |
| q_i | input | 2 | Quarter-tick fraction to load |
| sec_pulse_o | output | 1 | One-cycle pulse at each second boundary |
| sub_pulse_o | output | 1 | One-cycle pulse at each 1/128-second step |
| frac_o | output | 7 | Sub-second position, LSB = 1/128 second |

## Verification
The hardest case is a load strobe that lands exactly on the last tick of a second, because the new pair must then skip one boundary. The bench aims for it by watching its own reference model's tick count at each falling edge and raising the strobe when the count reaches the final tick. The bench is built with a small nominal count (256) so that many four-second rotations and both clamp limits fit in a short run. It also uses gapped tick patterns so that idle cycles fall both mid-second and on boundaries.

// File: rtl/rtc_pre_pkg.sv
// Shared definitions for the fractional-trim second prescaler.
// Assumes the fraction is always two bits (a four-second rotation).
package rtc_pre_pkg;
    localparam int unsigned Q_W    = 2;
    localparam int unsigned FRAC_W = 7;
    typedef logic [Q_W-1:0] sec_idx_t;
endpackage

// File: rtl/rtc_trim_latch.sv
// Holds the pending and the active divide pair.
// A load clamps the integer into [P_MIN, P_MAX] and parks the pair.
// The pair becomes active only when apply_i marks a second boundary.
// Assumes that apply_i is high for at most one cycle per second.
module rtc_trim_latch
    import rtc_pre_pkg::*;
#(
    parameter int unsigned P_W   = 17,
    parameter int unsigned P_MIN = 17'h0FFBF,
    parameter int unsigned P_MAX = 17'h10040,
    parameter int unsigned P_NOM = 17'h10000
) (
    input  logic           clk_i,
    input  logic           rst_n_i,
    input  logic           load_i,
    input  logic [P_W-1:0] p_i,
    input  sec_idx_t       q_i,
    input  logic           apply_i,
    output logic [P_W-1:0] p_act_o,
    output sec_idx_t       q_act_o
);
    localparam logic [P_W-1:0] LO  = P_W'(P_MIN);
    localparam logic [P_W-1:0] HI  = P_W'(P_MAX);
    localparam logic [P_W-1:0] NOM = P_W'(P_NOM);

    logic           pend_q;
    logic [P_W-1:0] pend_p_q;
    sec_idx_t       pend_f_q;
    logic [P_W-1:0] p_clamped;

    // Purpose: force the requested integer into the legal window.
    always_comb begin
        if (p_i < LO)      p_clamped = LO;
        else if (p_i > HI) p_clamped = HI;
        else               p_clamped = p_i;
    end

    // Purpose: park loads and promote them at the boundary (a load wins over clearing).
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            pend_q   <= 1'b0;
            pend_p_q <= NOM;
            pend_f_q <= '0;
            p_act_o  <= NOM;
            q_act_o  <= '0;
        end else begin
            if (apply_i && pend_q) begin
                p_act_o <= pend_p_q;
                q_act_o <= pend_f_q;
            end
            if (load_i) begin
                pend_q   <= 1'b1;
                pend_p_q <= p_clamped;
                pend_f_q <= q_i;
            end else if (apply_i) begin
                pend_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_sec_counter.sv
// Counts ticks within a second and the four-second rotation index.
// The current second lasts P+1 ticks when index < Q, and P ticks otherwise.
// Assumes P is at least 2, which the clamp window guarantees.
module rtc_sec_counter
    import rtc_pre_pkg::*;
#(
    parameter int unsigned P_W = 17,
    localparam int unsigned CNT_W = P_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             tick_i,
    input  logic [P_W-1:0]   p_act_i,
    input  sec_idx_t         q_act_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o,
    output logic             sec_pulse_o
);
    sec_idx_t         idx_q;
    logic [CNT_W-1:0] len;

    // Purpose: length of the current second, including the fractional stretch.
    always_comb begin
        len        = CNT_W'(p_act_i) + CNT_W'(idx_q < q_act_i);
        boundary_o = tick_i && (cnt_o == len - CNT_W'(1));
    end

    // Purpose: advance the tick count, wrap at the boundary and step the index.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_o       <= '0;
            idx_q       <= '0;
            sec_pulse_o <= 1'b0;
        end else begin
            sec_pulse_o <= boundary_o;
            if (boundary_o) begin
                cnt_o <= '0;
                idx_q <= idx_q + sec_idx_t'(1);
            end else if (tick_i) begin
                cnt_o <= cnt_o + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rtc_subsec_scale.sv
// Maps the in-second tick count to a 1/128-second position by shifting.
// Saturates at 127 in stretched seconds. Raises a pulse when the position steps.
// Assumes the nominal count is 2^NOM_LOG2 with NOM_LOG2 >= 7.
module rtc_subsec_scale
    import rtc_pre_pkg::*;
#(
    parameter int unsigned CNT_W    = 18,
    parameter int unsigned NOM_LOG2 = 16,
    localparam int unsigned SHIFT   = NOM_LOG2 - FRAC_W
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic              boundary_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              sub_pulse_o
);
    localparam logic [CNT_W-1:0] STEP_MASK = CNT_W'((64'd1 << SHIFT) - 64'd1);
    localparam logic [CNT_W-1:0] FRAC_TOP  = CNT_W'((64'd1 << FRAC_W) - 64'd1);

    logic [CNT_W-1:0] cur_pos;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] nxt_pos;

    // Purpose: present position and the position the next tick would reach.
    always_comb begin
        cur_pos = cnt_i >> SHIFT;
        nxt_cnt = cnt_i + CNT_W'(1);
        nxt_pos = nxt_cnt >> SHIFT;
        frac_o  = (cur_pos > FRAC_TOP) ? FRAC_TOP[FRAC_W-1:0] : cur_pos[FRAC_W-1:0];
    end

    // Purpose: register the step pulse so it lines up with the count update.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sub_pulse_o <= 1'b0;
        else          sub_pulse_o <= tick_i && !boundary_i
                                     && ((nxt_cnt & STEP_MASK) == '0)
                                     && (nxt_pos <= FRAC_TOP);
    end
endmodule

// File: rtl/rtc_trim_prescaler.sv
// Top of the fractional-trim second prescaler.
// Ties together the pair latch, the second counter and the sub-second scaler.
// Assumes tick_i is a one-cycle enable in the clk_i domain.
module rtc_trim_prescaler
    import rtc_pre_pkg::*;
#(
    parameter int unsigned P_W      = 17,
    parameter int unsigned NOM_LOG2 = 16,
    parameter int unsigned P_MIN    = 17'h0FFBF,
    parameter int unsigned P_MAX    = 17'h10040
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [P_W-1:0]    p_i,
    input  logic [1:0]        q_i,
    output logic              sec_pulse_o,
    output logic              sub_pulse_o,
    output logic [FRAC_W-1:0] frac_o
);
    localparam int unsigned CNT_W = P_W + 1;
    localparam int unsigned P_NOM = 1 << NOM_LOG2;

    logic [P_W-1:0]   p_act;
    sec_idx_t         q_act;
    logic [CNT_W-1:0] cnt;
    logic             boundary;

    rtc_trim_latch #(.P_W(P_W), .P_MIN(P_MIN), .P_MAX(P_MAX), .P_NOM(P_NOM)) u_latch (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .load_i(load_i), .p_i(p_i), .q_i(q_i),
        .apply_i(boundary), .p_act_o(p_act), .q_act_o(q_act)
    );

    rtc_sec_counter #(.P_W(P_W)) u_cnt (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i), .p_act_i(p_act),
        .q_act_i(q_act), .cnt_o(cnt), .boundary_o(boundary), .sec_pulse_o(sec_pulse_o)
    );

    rtc_subsec_scale #(.CNT_W(CNT_W), .NOM_LOG2(NOM_LOG2)) u_sub (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i), .boundary_i(boundary),
        .cnt_i(cnt), .frac_o(frac_o), .sub_pulse_o(sub_pulse_o)
    );
endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
// Property checker for the prescaler, attached to every instance by bind.
module rtc_trim_prescaler_chk #(
    parameter int unsigned P_W   = 17,
    parameter int unsigned P_MIN = 17'h0FFBF,
    parameter int unsigned P_MAX = 17'h10040
) (
    input logic           clk_i,
    input logic           rst_n_i,
    input logic           tick_i,
    input logic           sec_pulse_o,
    input logic           sub_pulse_o,
    input logic [6:0]     frac_o,
    input logic [P_W-1:0] p_act_i
);
    a_r5_active_in_window: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (p_act_i >= P_W'(P_MIN)) && (p_act_i <= P_W'(P_MAX)));

    a_r4_switch_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !sec_pulse_o |-> $stable(p_act_i));

    a_r6_zero_at_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sec_pulse_o |-> (frac_o == 7'd0));

    a_r6_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !sec_pulse_o |-> (frac_o >= $past(frac_o)));

    a_r7_pulses_apart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(sec_pulse_o && sub_pulse_o));

    a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$past(tick_i) |-> ($stable(frac_o) && !sec_pulse_o && !sub_pulse_o));
endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(.P_W(P_W), .P_MIN(P_MIN), .P_MAX(P_MAX)) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i), .sec_pulse_o(sec_pulse_o),
    .sub_pulse_o(sub_pulse_o), .frac_o(frac_o), .p_act_i(p_act)
);

// File: tb/tb_rtc_trim_prescaler.sv
// Bench with a behavioural reference model, compared at every falling edge.
module tb_rtc_trim_prescaler;
    localparam int NL   = 8;
    localparam int NOM  = 1 << NL;
    localparam int PMIN = NOM - 65;
    localparam int PMAX = NOM + 64;
    localparam int SH   = NL - 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, load = 1'b0;
    logic [16:0] p_in = '0;
    logic [1:0]  q_in = '0;
    logic sec_o, sub_o;
    logic [6:0] frac_o;

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit armed = 0;
    string cur_req = "R1";

    // reference state
    int m_cnt, m_k, m_p, m_q, m_pp, m_pq;
    bit m_pend, e_sec, e_sub;

    always #5 clk = ~clk;

    rtc_trim_prescaler #(.P_W(17), .NOM_LOG2(NL), .P_MIN(PMIN), .P_MAX(PMAX)) dut (
        .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .load_i(load), .p_i(p_in), .q_i(q_in),
        .sec_pulse_o(sec_o), .sub_pulse_o(sub_o), .frac_o(frac_o)
    );

    function automatic int cur_len();
        return m_p + ((m_k < m_q) ? 1 : 0);
    endfunction

    function automatic int clampv(input int v);
        return (v < PMIN) ? PMIN : ((v > PMAX) ? PMAX : v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // reference model: advances on each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        cycles++;
        armed = 1;
        if (!rst_n) begin
            m_cnt = 0; m_k = 0; m_p = NOM; m_q = 0; m_pp = NOM; m_pq = 0;
            m_pend = 0; e_sec = 0; e_sub = 0;
        end else begin
            e_sec = 0; e_sub = 0;
            if (tick) begin
                if (m_cnt == cur_len() - 1) begin
                    m_cnt = 0; m_k = (m_k + 1) % 4; e_sec = 1;
                    if (m_pend) begin m_p = m_pp; m_q = m_pq; m_pend = 0; end
                end else begin
                    m_cnt++;
                    if ((m_cnt % (1 << SH)) == 0 && (m_cnt >> SH) <= 127) e_sub = 1;
                end
            end
            if (load) begin m_pp = clampv(int'(p_in)); m_pq = int'(q_in); m_pend = 1; end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (armed) begin
            chk({cur_req, " sec"}, int'(sec_o), int'(e_sec));
            chk("R7 sub", int'(sub_o), int'(e_sub));
            chk("R6 frac", int'(frac_o), ((m_cnt >> SH) > 127) ? 127 : (m_cnt >> SH));
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic drive(input logic t, input logic ld, input int p, input int q);
        @(negedge clk);
        tick = t; load = ld; p_in = 17'(p); q_in = 2'(q);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 0, 0);
    endtask

    task automatic load_mid(input int p, input int q);
        run(37);
        drive(1'b1, 1'b1, p, q);
    endtask

    initial begin
        // R1: reset state
        repeat (3) drive(1'b1, 1'b0, 0, 0);
        drive(1'b0, 1'b0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frac", int'(frac_o), 0);
        chk("R1 sec", int'(sec_o), 0);
        chk("R1 sub", int'(sub_o), 0);
        // R1/R2: nominal length, no fraction
        cur_req = "R2";
        run(4 * NOM + 10);
        // R4 then R3: load mid-second, three stretched seconds per rotation
        cur_req = "R4";
        load_mid(NOM + 20, 3);
        run(NOM);
        cur_req = "R3";
        run(9 * (NOM + 21));
        load_mid(NOM - 30, 1);
        run(8 * NOM);
        // R5: clamps below and above the window
        cur_req = "R5";
        load_mid(100, 2);
        run(5 * NOM);
        load_mid(17'h1FFFF, 0);
        run(5 * PMAX);
        // R9: load exactly on the final tick of a second
        cur_req = "R9";
        load_mid(NOM + 5, 1);
        begin
            bit hit = 0;
            while (!hit) begin
                @(negedge clk);
                load = 1'b0; tick = 1'b1;
                if (m_cnt == cur_len() - 1 && m_cnt > 0) begin
                    load = 1'b1; p_in = 17'(NOM - 7); q_in = 2'd2; hit = 1;
                end
            end
        end
        run(6 * PMAX);
        // R8: gapped ticks, including a load while idle
        cur_req = "R8";
        for (int i = 0; i < 8 * NOM; i++)
            drive((i % 3) != 2, (i == 100), NOM + 3, 3);
        run(10);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule